// File: doc/BRIEF.md
# Latchable GPIO Input Interrupt Logic

This block watches a 16-pin general-purpose input port, organised as two 8-bit input registers, and drives an active-low interrupt line when a pin changes level. Each pin brings its own mode bit. In transparent mode the register bit follows the pin. The interrupt only lasts while the pin differs from its reference level, so a pulse that returns before the host reads the register is lost. In latched mode the first level that differs from the reference is captured. That captured value and its interrupt then stay in place until the host reads the byte that holds the pin. This holds even if the pin has meanwhile gone back to its old level.

The pins arrive from the pad ring already in the core clock's domain, and each passes through a two-flop synchroniser. A read is one clock with a read enable and a byte address. The byte's register value appears combinationally on the read data, and the clock edge that samples the read clears that byte's pending state. A pin that still differs from the value just read raises the interrupt again. Per-pin mask bits and output-direction bits keep pins from contributing to the interrupt.

Top module: `gpio_latch_irq`

## Requirements
- R1: With `rd_addr_i` = 0, `rd_data_o` carries pins 7..0 (bit n is pin n); with `rd_addr_i` = 1 it carries pins 15..8 (bit n is pin 8+n).
- R2: After reset is released with pins held steady, `irq_n_o` stays 1 and every register bit equals its pin level; the interrupt never goes low during the first three clocks after release.
- R3: For an unmasked input pin with `latch_en_i` bit 0 (transparent), a level change causes `irq_n_o` to be 0 from the second rising edge after the change, and the pin's register bit shows the new level.
- R4: In transparent mode, a pin that returns to its reference level before any read drops its interrupt request (`irq_n_o` back to 1 when nothing else is pending), and its register bit follows the pin.
- R5: With `latch_en_i` bit 1, the first differing level is captured on the third rising edge after the change. After that, a return of the pin to its old level leaves `irq_n_o` at 0 and the register bit at the captured level.
- R6: A read (`rd_en_i` = 1 at a rising edge) clears the pending state and updates the reference level only for pins of the byte at `rd_addr_i`. Pending pins of the other byte keep the interrupt asserted.
- R7: After a read in latched mode, the reference becomes the value that was read and the bit follows the live pin again. If the live pin differs from that value, the interrupt is asserted right after the read edge and the new level is captured.
- R8: A pin with `irq_mask_i` bit 1 does not pull `irq_n_o` low. A pin with `dir_out_i` bit 1 never pulls it low and keeps no pending state, and its reference tracks the pin.
- R9: `irq_n_o` is 0 exactly when at least one unmasked input pin is pending, and 1 otherwise (active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_i | input | 16 | Pin levels from the pads |
| dir_out_i | input | 16 | 1 = pin configured as output, excluded from interrupts |
| latch_en_i | input | 16 | 1 = latched mode, 0 = transparent mode |
| irq_mask_i | input | 16 | 1 = pin blocked from the interrupt |
| rd_en_i | input | 1 | Read strobe, one clock per byte read |
| rd_addr_i | input | 1 | Byte select for reads and read data |
| rd_data_o | output | 8 | Input register of the selected byte |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
Two functions can fall in the same clock: a host read of a byte, and a fresh capture of a pin in that byte, or of a pin in the other byte. The bench provokes this by timing pin changes so that the synchronised level first differs at exactly the edge that samples the read. It also issues reads to one byte while pins of both bytes are pending, and reads a latched pin whose live level has already moved on. A behavioural model steps alongside on every clock and judges `irq_n_o` and `rd_data_o`, so the read must win over the capture for the byte read and leave the other byte untouched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Operating mode of one pin, decoded from its direction and latch bits.
  typedef enum logic [1:0] {
    PIN_OUTPUT      = 2'd0,
    PIN_TRANSPARENT = 2'd1,
    PIN_LATCHED     = 2'd2
  } pin_mode_e;

  function automatic pin_mode_e decode_mode(input logic is_out, input logic latch);
    if (is_out)     return PIN_OUTPUT;
    else if (latch) return PIN_LATCHED;
    else            return PIN_TRANSPARENT;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_start_ctl.sv
module gpio_start_ctl #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_done_o
);

  // The reference levels are loaded from the synchroniser output on the
  // first STAGES+1 edges after reset; after that, change detection runs.
  localparam int LAST  = STAGES + 1;
  localparam int CNT_W = $clog2(LAST + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (cnt_q != CNT_W'(LAST));
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign init_done_o = ~cnt_en;

endmodule

// File: rtl/gpio_pin_track.sv
module gpio_pin_track
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_done_i,
  input  logic level_i,
  input  logic is_out_i,
  input  logic latch_i,
  input  logic rd_hit_i,
  output logic reg_bit_o,
  output logic active_o
);

  logic      ref_q, ref_d;
  logic      held_q, held_d;
  logic      cap_q, cap_d;
  logic      differs;
  pin_mode_e mode;

  always_comb begin
    mode      = decode_mode(is_out_i, latch_i);
    differs   = (level_i != ref_q);
    reg_bit_o = held_q ? cap_q : level_i;
    active_o  = init_done_i && (mode != PIN_OUTPUT) && (held_q || differs);
  end

  always_comb begin
    ref_d  = ref_q;
    held_d = held_q;
    cap_d  = cap_q;
    if (!init_done_i || mode == PIN_OUTPUT) begin
      ref_d  = level_i;
      held_d = 1'b0;
    end else if (rd_hit_i) begin
      ref_d  = reg_bit_o;
      held_d = 1'b0;
    end else if (mode == PIN_TRANSPARENT) begin
      held_d = 1'b0;
    end else if (!held_q && differs) begin
      held_d = 1'b1;
      cap_d  = level_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      held_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      held_q <= held_d;
      cap_q  <= cap_d;
    end
  end

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int ADDR_W    = 1,
  localparam int PIN_W    = BYTE_W * NUM_BYTES
) (
  input  logic [PIN_W-1:0]  reg_bits_i,
  input  logic [PIN_W-1:0]  active_i,
  input  logic [PIN_W-1:0]  mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_n_o
);

  logic [BYTE_W-1:0] byte_val [NUM_BYTES];

  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      assign byte_val[b] = reg_bits_i[b*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (rd_addr_i == ADDR_W'(b)) rd_data_o = byte_val[b];
    end
    irq_n_o = ~|(active_i & ~mask_i);
  end

endmodule

// File: rtl/gpio_latch_irq.sv
module gpio_latch_irq #(
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W      = BYTE_W * NUM_BYTES,
  localparam int ADDR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pin_i,
  input  logic [PIN_W-1:0]  dir_out_i,
  input  logic [PIN_W-1:0]  latch_en_i,
  input  logic [PIN_W-1:0]  irq_mask_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_n_o
);

  logic [PIN_W-1:0] level;
  logic [PIN_W-1:0] reg_bits;
  logic [PIN_W-1:0] active;
  logic             init_done;

  gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (level)
  );

  gpio_start_ctl #(.STAGES(SYNC_STAGES)) u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_done_o (init_done)
  );

  generate
    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
      logic rd_hit;
      assign rd_hit = init_done && rd_en_i && (rd_addr_i == ADDR_W'(p / BYTE_W));
      gpio_pin_track u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_done_i (init_done),
        .level_i     (level[p]),
        .is_out_i    (dir_out_i[p]),
        .latch_i     (latch_en_i[p]),
        .rd_hit_i    (rd_hit),
        .reg_bit_o   (reg_bits[p]),
        .active_o    (active[p])
      );
    end
  endgenerate

  gpio_irq_combine #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_comb (
    .reg_bits_i (reg_bits),
    .active_i   (active),
    .mask_i     (irq_mask_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .irq_n_o    (irq_n_o)
  );

endmodule

// File: rtl/gpio_latch_irq_chk.sv
module gpio_latch_irq_chk #(
  parameter int PIN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_done,
  input logic [PIN_W-1:0] dir_out_i,
  input logic [PIN_W-1:0] latch_en_i,
  input logic [PIN_W-1:0] irq_mask_i,
  input logic             rd_en_i,
  input logic             irq_n_o
);

  assert_start_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> irq_n_o);

  assert_latched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(init_done) && init_done && (&latch_en_i) && $past(&latch_en_i) &&
     $past(!rd_en_i) && $past(!irq_n_o) && $stable(irq_mask_i) && $stable(dir_out_i))
    |-> !irq_n_o);

  assert_all_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask_i) |-> irq_n_o);

  assert_all_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&dir_out_i) |-> irq_n_o);

  assert_irq_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(irq_n_o));

endmodule

bind gpio_latch_irq gpio_latch_irq_chk #(.PIN_W(PIN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_done  (init_done),
  .dir_out_i  (dir_out_i),
  .latch_en_i (latch_en_i),
  .irq_mask_i (irq_mask_i),
  .rd_en_i    (rd_en_i),
  .irq_n_o    (irq_n_o)
);

// File: tb/gpio_latch_irq_test.sv
`timescale 1ns/1ps
module gpio_latch_irq_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] pin_i, dir_out_i, latch_en_i, irq_mask_i;
  logic        rd_en_i;
  logic [0:0]  rd_addr_i;
  logic [7:0]  rd_data_o;
  logic        irq_n_o;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R2";
  bit    finished = 0;

  gpio_latch_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .dir_out_i(dir_out_i),
    .latch_en_i(latch_en_i), .irq_mask_i(irq_mask_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge.
  logic [15:0] m_s1, m_s2, m_ref, m_held, m_cap;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ref = 0; m_held = 0; m_cap = 0; m_cnt = 0;
    end else begin
      logic [15:0] nref, nheld, ncap;
      bit done;
      done  = (m_cnt == 3);
      nref  = m_ref; nheld = m_held; ncap = m_cap;
      for (int i = 0; i < 16; i++) begin
        bit iv, hit;
        iv  = m_held[i] ? m_cap[i] : m_s2[i];
        hit = done && rd_en_i && (int'(rd_addr_i) == i / 8);
        if (!done || dir_out_i[i]) begin
          nref[i] = m_s2[i]; nheld[i] = 0;
        end else if (hit) begin
          nref[i] = iv; nheld[i] = 0;
        end else if (!latch_en_i[i]) begin
          nheld[i] = 0;
        end else if (!m_held[i] && (m_s2[i] != m_ref[i])) begin
          nheld[i] = 1; ncap[i] = m_s2[i];
        end
      end
      m_ref = nref; m_held = nheld; m_cap = ncap;
      m_s2 = m_s1; m_s1 = pin_i;
      if (m_cnt < 3) m_cnt++;
    end
  end

  function automatic logic [15:0] model_regs();
    return (m_held & m_cap) | (~m_held & m_s2);
  endfunction

  function automatic logic model_irq_n();
    logic [15:0] act;
    if (m_cnt != 3) return 1'b1;
    act = (m_held | (m_s2 ^ m_ref)) & ~dir_out_i & ~irq_mask_i;
    return ~|act;
  endfunction

  // Per-cycle comparison away from the rising edge.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic [15:0] r;
      r = model_regs();
      chk({phase, " irq"}, {31'd0, irq_n_o}, {31'd0, model_irq_n()});
      chk({phase, " rdata"}, {24'd0, rd_data_o}, {24'd0, r[rd_addr_i*8 +: 8]});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic a);
    @(negedge clk);
    rd_addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic look(input string req, input logic a, input logic irq_exp, input logic [7:0] dat_exp);
    rd_addr_i = a;
    #1;
    chk({req, " irq_n"}, {31'd0, irq_n_o}, {31'd0, irq_exp});
    chk({req, " data"}, {24'd0, rd_data_o}, {24'd0, dat_exp});
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin_i = 16'hA55A; dir_out_i = 0; latch_en_i = 0; irq_mask_i = 0;
    rd_en_i = 0; rd_addr_i = 0;
    cyc(3);
    rst_n = 1;
    // R2: quiet during startup and after
    cyc(1); #1 chk("R2 startup irq_n", {31'd0, irq_n_o}, 32'd1);
    cyc(5);
    look("R2", 1'b0, 1'b1, 8'h5A);
    look("R1 byte1", 1'b1, 1'b1, 8'hA5);

    // R3 transparent change
    phase = "R3";
    @(negedge clk); pin_i = 16'hA55B;
    cyc(1); look("R3 before sync", 1'b0, 1'b1, 8'h5A);
    cyc(1); look("R3", 1'b0, 1'b0, 8'h5B);
    // R4 return before read: event lost
    phase = "R4";
    @(negedge clk); pin_i = 16'hA55A;
    cyc(2); look("R4", 1'b0, 1'b1, 8'h5A);
    // transparent change then read clears
    phase = "R6";
    @(negedge clk); pin_i = 16'hA552;
    cyc(2); look("R3 second", 1'b0, 1'b0, 8'h52);
    do_read(1'b0);
    look("R6 transparent read", 1'b0, 1'b1, 8'h52);

    // R5 latched capture survives return
    phase = "R5";
    latch_en_i = 16'hFFFF;
    @(negedge clk); pin_i = 16'hA752;
    cyc(3);
    @(negedge clk); pin_i = 16'hA552;
    cyc(3); look("R5 held", 1'b1, 1'b0, 8'hA7);
    // R7 read while live pin differs: re-raise and recapture
    phase = "R7";
    do_read(1'b1);
    look("R7 reraise", 1'b1, 1'b0, 8'hA5);
    cyc(1); look("R7 recaptured", 1'b1, 1'b0, 8'hA5);
    do_read(1'b1);
    look("R7 cleared", 1'b1, 1'b1, 8'hA5);

    // R6 read of one byte leaves the other pending
    phase = "R6";
    @(negedge clk); pin_i = 16'hB556;
    cyc(4);
    do_read(1'b0);
    look("R6 byte1 still pending", 1'b0, 1'b0, 8'h56);
    do_read(1'b1);
    look("R6 both read", 1'b1, 1'b1, 8'hB5);
    // Read at the same edge the synchronised change arrives
    @(negedge clk); pin_i = 16'hB516;
    cyc(1);
    rd_addr_i = 1'b0; rd_en_i = 1'b1;
    @(negedge clk); rd_en_i = 1'b0;
    cyc(3);
    do_read(1'b0);
    look("R6 collision settled", 1'b0, 1'b1, 8'h16);

    // R8 mask and direction
    phase = "R8";
    irq_mask_i = 16'hFFFF;
    @(negedge clk); pin_i = 16'hB536;
    cyc(4); look("R8 masked", 1'b0, 1'b1, 8'h36);
    irq_mask_i = 16'h0000;
    look("R9 unmasked pending", 1'b0, 1'b0, 8'h36);
    do_read(1'b0);
    dir_out_i = 16'h00F0;
    @(negedge clk); pin_i = 16'hB576;
    cyc(4); look("R8 output pin", 1'b0, 1'b1, 8'h76);
    dir_out_i = 16'h0000;
    cyc(2); look("R8 no residue", 1'b0, 1'b1, 8'h76);

    // Mixed traffic judged by the model each cycle
    phase = "R9";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pin_i = pin_i ^ (16'h1 << $urandom_range(0, 15));
      if ($urandom_range(0, 63) == 0) latch_en_i = 16'($urandom);
      if ($urandom_range(0, 63) == 0) irq_mask_i = 16'($urandom) & 16'($urandom);
      if ($urandom_range(0, 127) == 0) dir_out_i = 16'($urandom) & 16'($urandom) & 16'($urandom);
      rd_addr_i = 1'($urandom_range(0, 1));
      rd_en_i   = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk); rd_en_i = 0;
    cyc(4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule